// File: doc/BRIEF.md
# Two-Wire Bus Ownership Controller

This block is the master-side half of a two-signal bus handshake. An external arbiter hands the shared bus to this master with an active-low grant input. The block answers with an active-low bus-driven output, which is asserted only while the block actually owns and drives the bus. Internal agents present access requests. The block decides when a request may start, issues a one-cycle transfer-start strobe, and tracks the transfer until the transfer-acknowledge input is seen. It also produces the output-enable controls for the address, attribute, control and data pin drivers.

The block has three ownership conditions. With no grant, it is not granted. With a grant and nothing to do, it holds implicit ownership: the bus belongs to it, but nothing is driven and bus-driven stays negated. With a grant and a request, it takes explicit ownership: it drives the bus and asserts bus-driven. Explicit ownership continues between transfers for as long as the grant stays asserted. If the grant is withdrawn during a transfer, the block still finishes that transfer before it lets go of the bus. The grant input passes through a register stage before any decision uses it.

Top module: `busown_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, bus-driven and transfer-start and transfer-in-progress are all high (negated), request-accept is 0, and all four output enables are 0.
- R2: With grant asserted and no request, the block stays in implicit ownership. In this state bus-driven stays high and every output enable stays 0, for as many cycles as the condition lasts.
- R3: When a request appears during implicit ownership, the next rising edge pulls transfer-start low, asserts request-accept, pulls bus-driven low, and turns on the address, attribute and control enables.
- R4: When grant_n falls while a request is already waiting, bus-driven and transfer-start go low together on the second rising edge after the fall. The first edge only loads the grant register.
- R5: Transfer-start is low for exactly one cycle for each transfer. Transfer-in-progress is low from the start cycle through the cycle in which ack_n is sampled low, and it goes high on the edge that samples ack_n low.
- R6: After a transfer ends with the grant still asserted, bus-driven stays low and the address, attribute and control enables stay 1. The data enable is 0 and transfer-in-progress is high.
- R7: If grant_n rises during a transfer, bus-driven and the enables hold until ack_n is sampled low. On that edge bus-driven goes high and all enables go to 0.
- R8: If the grant is withdrawn during implicit ownership, the block returns to not granted and never pulls bus-driven low or turns on an enable.
- R9: A request that arrives while the block is not granted gets no transfer-start, no request-accept and no bus-driven until the grant comes. It is then served as in R4.
- R10: The data enable is 1 only during a transfer whose req_write was 1 when the request was accepted. It is 0 during read transfers.
- R11: No output enable is ever 1 while bus-driven is high, and bus-driven is never high while transfer-in-progress is low.
- R12: If grant_n rises while the block is in explicit ownership between transfers, bus-driven goes high and all enables go to 0 on the second rising edge after the rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| grant_n | input | 1 | Bus grant from the external arbiter, active low |
| ack_n | input | 1 | Transfer acknowledge from the addressed slave, active low |
| req_valid | input | 1 | Internal access request, held high until it is accepted |
| req_write | input | 1 | Direction of the requested access, 1 = write |
| req_accept | output | 1 | One-cycle pulse: the request has been taken |
| busdrv_n | output | 1 | Bus-driven indication, low while this master owns and drives the bus |
| start_n | output | 1 | Transfer-start strobe, low for one cycle |
| xip_n | output | 1 | Transfer in progress, active low |
| addr_oe | output | 1 | Address pin driver enable |
| attr_oe | output | 1 | Attribute pin driver enable |
| ctrl_oe | output | 1 | Control pin driver enable |
| data_oe | output | 1 | Data pin driver enable |

## Verification
The embedded assertions check the invariants on every cycle:
- an enable is never on without bus-driven;
- bus-driven never drops while a transfer is open;
- the start strobe is always a single cycle, and a start always follows a registered grant;
- an acknowledged transfer with the grant gone always releases the bus on the next edge.

The directed scenarios are needed for the behaviour that depends on history and on exact timing. These are the two-edge latency from a grant to the first start, the quiet implicit state, the hold of a request that arrived before the grant, and the direction-dependent data enable.

// File: rtl/busown_pkg.sv
package busown_pkg;

    typedef enum logic [1:0] {
        OWN_NOGRANT  = 2'd0,
        OWN_IMPLICIT = 2'd1,
        OWN_ACTIVE   = 2'd2,
        OWN_PARKED   = 2'd3
    } own_state_e;

    typedef struct packed {
        own_state_e state;
        logic       start;
        logic       accept;
        logic       wr;
    } own_regs_s;

    localparam own_regs_s OWN_REGS_RESET = '{
        state:  OWN_NOGRANT,
        start:  1'b0,
        accept: 1'b0,
        wr:     1'b0
    };

endpackage

// File: rtl/busown_grant_reg.sv
module busown_grant_reg #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant_i,
    output logic grant_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d;
    logic [LAST:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = grant_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[LAST-1:0], grant_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign grant_o = chain_q[LAST];

    initial begin
        assert (STAGES >= 1) else $error("grant register needs at least one stage");
    end
endmodule

// File: rtl/busown_fsm.sv
module busown_fsm
    import busown_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       grant_i,
    input  logic       req_valid_i,
    input  logic       req_write_i,
    input  logic       ack_i,
    output own_state_e state_o,
    output logic       start_o,
    output logic       accept_o,
    output logic       wr_o
);
    own_regs_s r_d;
    own_regs_s r_q;

    logic take_req;
    assign take_req = grant_i && req_valid_i;

    always_comb begin
        r_d        = r_q;
        r_d.start  = 1'b0;
        r_d.accept = 1'b0;
        case (r_q.state)
            OWN_NOGRANT, OWN_IMPLICIT, OWN_PARKED: begin
                if (!grant_i) begin
                    r_d.state = OWN_NOGRANT;
                end else if (take_req) begin
                    r_d.state  = OWN_ACTIVE;
                    r_d.start  = 1'b1;
                    r_d.accept = 1'b1;
                    r_d.wr     = req_write_i;
                end else if (r_q.state == OWN_NOGRANT) begin
                    r_d.state = OWN_IMPLICIT;
                end
            end
            OWN_ACTIVE: begin
                if (ack_i) begin
                    r_d.state = grant_i ? OWN_PARKED : OWN_NOGRANT;
                end
            end
            default: r_d.state = OWN_NOGRANT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= OWN_REGS_RESET;
        else        r_q <= r_d;
    end

    assign state_o  = r_q.state;
    assign start_o  = r_q.start;
    assign accept_o = r_q.accept;
    assign wr_o     = r_q.wr;

    p_start_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.start |=> !r_q.start);

    p_start_after_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.start) |-> $past(grant_i));

    p_xip_until_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == OWN_ACTIVE && !ack_i) |=> (r_q.state == OWN_ACTIVE));

    p_implicit_needs_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != OWN_ACTIVE && !grant_i) |=> (r_q.state == OWN_NOGRANT));
endmodule

// File: rtl/busown_outdec.sv
module busown_outdec
    import busown_pkg::*;
(
    input  own_state_e state_i,
    input  logic       wr_i,
    output logic       owner_o,
    output logic       xip_o,
    output logic       addr_oe_o,
    output logic       attr_oe_o,
    output logic       ctrl_oe_o,
    output logic       data_oe_o
);
    always_comb begin
        owner_o   = (state_i == OWN_ACTIVE) || (state_i == OWN_PARKED);
        xip_o     = (state_i == OWN_ACTIVE);
        addr_oe_o = owner_o;
        attr_oe_o = owner_o;
        ctrl_oe_o = owner_o;
        data_oe_o = xip_o && wr_i;
    end
endmodule

// File: rtl/busown_ctrl.sv
module busown_ctrl
    import busown_pkg::*;
#(
    parameter int GRANT_STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant_n,
    input  logic ack_n,
    input  logic req_valid,
    input  logic req_write,
    output logic req_accept,
    output logic busdrv_n,
    output logic start_n,
    output logic xip_n,
    output logic addr_oe,
    output logic attr_oe,
    output logic ctrl_oe,
    output logic data_oe
);
    logic       grant_q;
    own_state_e state;
    logic       start;
    logic       wr;
    logic       owner;
    logic       xip;

    busown_grant_reg #(.STAGES(GRANT_STAGES)) u_grant (
        .clk     (clk),
        .rst_n   (rst_n),
        .grant_i (~grant_n),
        .grant_o (grant_q)
    );

    busown_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_i     (grant_q),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .ack_i       (~ack_n),
        .state_o     (state),
        .start_o     (start),
        .accept_o    (req_accept),
        .wr_o        (wr)
    );

    busown_outdec u_dec (
        .state_i   (state),
        .wr_i      (wr),
        .owner_o   (owner),
        .xip_o     (xip),
        .addr_oe_o (addr_oe),
        .attr_oe_o (attr_oe),
        .ctrl_oe_o (ctrl_oe),
        .data_oe_o (data_oe)
    );

    assign busdrv_n = ~owner;
    assign start_n  = ~start;
    assign xip_n    = ~xip;

    p_oe_needs_bd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_oe || attr_oe || ctrl_oe || data_oe) |-> !busdrv_n);

    p_bd_during_xfer_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !xip_n |-> !busdrv_n);

    p_release_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!xip_n && !ack_n && !grant_q) |=> (busdrv_n && !addr_oe && !data_oe));

    p_start_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !start_n |-> (!busdrv_n && req_accept && !xip_n));
endmodule

// File: tb/busown_ctrl_test.sv
`timescale 1ns/1ps
module busown_ctrl_test;
    logic clk = 1'b0;
    logic rst_n, grant_n, ack_n, req_valid, req_write;
    logic req_accept, busdrv_n, start_n, xip_n;
    logic addr_oe, attr_oe, ctrl_oe, data_oe;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    busown_ctrl uut (
        .clk(clk), .rst_n(rst_n), .grant_n(grant_n), .ack_n(ack_n),
        .req_valid(req_valid), .req_write(req_write), .req_accept(req_accept),
        .busdrv_n(busdrv_n), .start_n(start_n), .xip_n(xip_n),
        .addr_oe(addr_oe), .attr_oe(attr_oe), .ctrl_oe(ctrl_oe), .data_oe(data_oe)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
        end
    endtask

    // R11 invariant is checked after every edge
    task automatic tick();
        @(posedge clk);
        #1;
        chk("R11", "enable without bus-driven",
            (addr_oe | attr_oe | ctrl_oe | data_oe) & busdrv_n, 1'b0);
        chk("R11", "bus-driven high during transfer", ~xip_n & busdrv_n, 1'b0);
    endtask

    task automatic check_quiet(input string tag);
        chk(tag, "busdrv_n", busdrv_n, 1'b1);
        chk(tag, "start_n", start_n, 1'b1);
        chk(tag, "req_accept", req_accept, 1'b0);
        chk(tag, "addr_oe", addr_oe, 1'b0);
        chk(tag, "attr_oe", attr_oe, 1'b0);
        chk(tag, "ctrl_oe", ctrl_oe, 1'b0);
        chk(tag, "data_oe", data_oe, 1'b0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0; grant_n = 1'b1; ack_n = 1'b1; req_valid = 1'b0; req_write = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check_quiet("R1");
        chk("R1", "xip_n in reset", xip_n, 1'b1);
        rst_n = 1'b1;
        tick();
        check_quiet("R1");
        chk("R1", "xip_n after reset", xip_n, 1'b1);
    endtask

    // R4, R5, R6, R10, R12: grant arrives with a write waiting
    task automatic test_grant_with_request();
        grant_n = 1'b0; req_valid = 1'b1; req_write = 1'b1;
        tick();
        chk("R4", "busdrv_n after first edge", busdrv_n, 1'b1);
        chk("R4", "start_n after first edge", start_n, 1'b1);
        tick();
        chk("R4", "busdrv_n after second edge", busdrv_n, 1'b0);
        chk("R4", "start_n after second edge", start_n, 1'b0);
        chk("R4", "req_accept", req_accept, 1'b1);
        chk("R5", "xip_n in start cycle", xip_n, 1'b0);
        chk("R10", "data_oe on write", data_oe, 1'b1);
        req_valid = 1'b0;
        tick();
        chk("R5", "start_n single cycle", start_n, 1'b1);
        chk("R5", "xip_n waiting for ack", xip_n, 1'b0);
        ack_n = 1'b0;
        tick();
        ack_n = 1'b1;
        chk("R5", "xip_n after ack", xip_n, 1'b1);
        chk("R6", "busdrv_n parked", busdrv_n, 1'b0);
        chk("R6", "addr_oe parked", addr_oe, 1'b1);
        chk("R6", "attr_oe parked", attr_oe, 1'b1);
        chk("R6", "ctrl_oe parked", ctrl_oe, 1'b1);
        chk("R6", "data_oe parked", data_oe, 1'b0);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R6", "busdrv_n stays", busdrv_n, 1'b0);
            chk("R6", "addr_oe stays", addr_oe, 1'b1);
        end
        grant_n = 1'b1;
        tick();
        chk("R12", "busdrv_n after first edge", busdrv_n, 1'b0);
        tick();
        check_quiet("R12");
    endtask

    // R2, R3, R7, R10: implicit, then a read, then grant pulled mid-transfer
    task automatic test_implicit_then_read();
        grant_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick();
            check_quiet("R2");
        end
        req_valid = 1'b1; req_write = 1'b0;
        tick();
        chk("R3", "start_n", start_n, 1'b0);
        chk("R3", "busdrv_n", busdrv_n, 1'b0);
        chk("R3", "req_accept", req_accept, 1'b1);
        chk("R3", "addr_oe", addr_oe, 1'b1);
        chk("R3", "ctrl_oe", ctrl_oe, 1'b1);
        chk("R10", "data_oe on read", data_oe, 1'b0);
        req_valid = 1'b0;
        grant_n = 1'b1;
        for (int i = 0; i < 2; i++) begin
            tick();
            chk("R7", "busdrv_n held", busdrv_n, 1'b0);
            chk("R7", "addr_oe held", addr_oe, 1'b1);
            chk("R7", "xip_n held", xip_n, 1'b0);
        end
        ack_n = 1'b0;
        tick();
        ack_n = 1'b1;
        check_quiet("R7");
        chk("R7", "xip_n released", xip_n, 1'b1);
    endtask

    // R8, R9: implicit ownership withdrawn, request waits for next grant
    task automatic test_withdraw_and_wait();
        grant_n = 1'b0;
        repeat (3) tick();
        grant_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            check_quiet("R8");
        end
        req_valid = 1'b1; req_write = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tick();
            check_quiet("R9");
        end
        grant_n = 1'b0;
        tick();
        chk("R9", "start_n one edge after grant", start_n, 1'b1);
        tick();
        chk("R9", "start_n two edges after grant", start_n, 1'b0);
        chk("R9", "req_accept", req_accept, 1'b1);
        chk("R10", "data_oe held write", data_oe, 1'b1);
        req_valid = 1'b0;
        ack_n = 1'b0;
        tick();
        ack_n = 1'b1;
        chk("R5", "xip_n after one-cycle ack", xip_n, 1'b1);
        chk("R6", "busdrv_n parked", busdrv_n, 1'b0);
        grant_n = 1'b1;
        tick();
        tick();
        check_quiet("R12");
    endtask

    initial begin
        test_reset();
        test_grant_with_request();
        test_implicit_then_read();
        test_withdraw_and_wait();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule